// File: doc/BRIEF.md
# SMRAM Base Relocation Register

This block keeps the processor's internal system-management memory base and turns it into the addresses the rest of the core needs. From the base it forms the handler entry point, the first and last byte of the state-save region, and the addresses of two words in that region: the saved base field and the revision identifier. It also supplies the constant revision identifier word. In that word the relocation-capable flag is set, the I/O-restart flag comes from a parameter, and the base version sits in the low half.

When the core enters system-management mode it pulses `smi_entry_i`. One cycle later the block presents a save write that carries the current base and the address of the saved base field. Software may then edit that field in memory. When the mode ends, the core pulses `resume_i` with the edited value on `saved_base_i`, and the block reloads its base from that value. The new value governs the next entry. A hardware reset restores the default base, and INIT leaves the base unchanged.

A static configuration input turns on an alignment check. When the check is on, a reload value that is not a multiple of 32 KB raises a sticky shutdown indication in place of the reload. The base then keeps its old value and later resumes are ignored until the next hardware reset.

Top module: `smbase_reloc`

## Requirements
- R1: After hardware reset `base_o` is 0x0003_0000 and `shutdown_o` and `save_wr_o` are 0.
- R2: `init_i`, and any change of `saved_base_i` without a resume strobe, leave `base_o` unchanged.
- R3: A cycle with `smi_entry_i` high is followed by exactly one cycle with `save_wr_o` high. In that cycle `save_data_o` equals the base held at entry and `save_addr_o` equals that base plus 0xFEF8.
- R4: A resume strobe (not in shutdown, not rejected by the alignment check) makes `base_o` equal the value `saved_base_i` had at that edge, from the next cycle on. With the check off, any value is accepted.
- R5: `handler_o` equals `base_o` plus 0x8000, modulo 2^32.
- R6: `save_lo_o` equals `base_o` plus 0xFE00 and `save_hi_o` equals `base_o` plus 0xFFFF, both modulo 2^32.
- R7: `rev_id_o` has bit 17 set, bit 16 set (default parameter), bits 15:0 equal to 0x0001 (default version) and bits 31:18 clear. `rev_addr_o` equals `base_o` plus 0xFEFC.
- R8: With `align_chk_en_i` high, a resume whose `saved_base_i` has any of bits 14:0 set raises `shutdown_o` in the next cycle and leaves `base_o` unchanged.
- R9: Once `shutdown_o` is high it stays high and `base_o` ignores resume strobes until hardware reset.
- R10: When entry and resume fall in the same cycle, the save write carries the old base and `base_o` takes the reloaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| init_i | input | 1 | INIT event; no effect on the base |
| align_chk_en_i | input | 1 | Static: enable the 32 KB alignment check on reload |
| smi_entry_i | input | 1 | One-cycle strobe at mode entry |
| resume_i | input | 1 | One-cycle strobe at mode exit |
| saved_base_i | input | 32 | Base value read back from the save area at exit |
| base_o | output | 32 | Current internal base |
| handler_o | output | 32 | Handler entry address |
| save_lo_o | output | 32 | First address of the state-save area |
| save_hi_o | output | 32 | Last address of the state-save area |
| rev_id_o | output | 32 | Revision identifier word |
| rev_addr_o | output | 32 | Address of the revision identifier word |
| save_wr_o | output | 1 | Save-field write strobe |
| save_addr_o | output | 32 | Address of the saved base field for the write |
| save_data_o | output | 32 | Base value written at entry |
| shutdown_o | output | 1 | Sticky shutdown after a misaligned reload |

## Verification
The bench sweeps several dozen reload values, both aligned and scattered, including bases near the top of the address space. A design that carried or truncated wrongly would show this as wrong handler or save-area bounds once the sum passes 2^32. It also drives entry and resume in the same cycle. A design that sampled the base after the update would write the new base into the save field rather than the old one. With the alignment check on, a value with only bit 14 set and one with only bit 0 set must both shut the block down, which exposes a check that is too narrow. Two resumes after shutdown show whether the lock is sticky and whether the base is really frozen.

// File: rtl/smbase_pkg.sv
package smbase_pkg;
  // Index of each derived address in the address generator
  typedef enum int unsigned {
    TAP_HANDLER  = 0,
    TAP_SAVE_LO  = 1,
    TAP_SAVE_HI  = 2,
    TAP_BASE_FLD = 3,
    TAP_REV_FLD  = 4
  } tap_e;

  localparam int unsigned NUM_TAPS = 5;

  function automatic logic [31:0] make_rev_word(input logic io_restart,
                                                 input logic [15:0] version);
    return {14'b0, 1'b1, io_restart, version};
  endfunction
endpackage

// File: rtl/smbase_addr_gen.sv
module smbase_addr_gen #(
  parameter int unsigned AW = 32,
  parameter int unsigned N  = 5,
  parameter logic [N-1:0][AW-1:0] OFS = '0
) (
  input  logic [AW-1:0]        base_i,
  output logic [N-1:0][AW-1:0] addr_o
);
  // One adder per tap, results wrap modulo 2^AW
  for (genvar g = 0; g < N; g++) begin : g_tap
    assign addr_o[g] = base_i + OFS[g];
  end
endmodule

// File: rtl/smbase_align_chk.sv
module smbase_align_chk #(
  parameter int unsigned AW         = 32,
  parameter int unsigned ALIGN_BITS = 15
) (
  input  logic          en_i,
  input  logic [AW-1:0] value_i,
  output logic          misaligned_o
);
  if (ALIGN_BITS == 0) begin : g_none
    assign misaligned_o = 1'b0;
  end else begin : g_chk
    assign misaligned_o = en_i & (|value_i[ALIGN_BITS-1:0]);
  end
endmodule

// File: rtl/smbase_core.sv
module smbase_core #(
  parameter int unsigned   AW       = 32,
  parameter logic [AW-1:0] RST_BASE = 32'h0003_0000
) (
  input  logic          clk_i,
  input  logic          rst_n,
  input  logic          init_i,
  input  logic          smi_entry_i,
  input  logic          resume_i,
  input  logic [AW-1:0] saved_base_i,
  input  logic          misaligned_i,
  input  logic          align_chk_en_i,
  input  logic [AW-1:0] fld_addr_i,
  output logic [AW-1:0] base_q,
  output logic          shut_q,
  output logic          save_vld_q,
  output logic [AW-1:0] save_addr_q,
  output logic [AW-1:0] save_data_q
);
  logic          reload_en;
  logic [AW-1:0] base_d;
  logic          shut_d;
  logic          base_en;

  // Next-state logic
  always_comb begin
    reload_en = resume_i & ~shut_q;
    base_d    = base_q;
    shut_d    = shut_q;
    base_en   = 1'b0;
    if (reload_en) begin
      if (misaligned_i) begin
        shut_d = 1'b1;
      end else begin
        base_d  = saved_base_i;
        base_en = 1'b1;
      end
    end
  end

  // State registers
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      base_q      <= RST_BASE;
      shut_q      <= 1'b0;
      save_vld_q  <= 1'b0;
      save_addr_q <= '0;
      save_data_q <= '0;
    end else begin
      if (base_en) base_q <= base_d;
      shut_q     <= shut_d;
      save_vld_q <= smi_entry_i;
      if (smi_entry_i) begin
        save_addr_q <= fld_addr_i;
        save_data_q <= base_q;
      end
    end
  end

  // R2: INIT alone never moves the base
  p_init_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (init_i && !resume_i) |=> $stable(base_q));

  // R3: entry yields a save write of the base held at entry
  p_save_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    smi_entry_i |=> (save_vld_q && save_data_q == $past(base_q)));

  // R4: accepted resume loads the sampled value
  p_reload_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (resume_i && !shut_q && !misaligned_i) |=> (base_q == $past(saved_base_i)));

  // R8: misaligned reload under check shuts down and keeps the base
  p_align_shut_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (resume_i && align_chk_en_i && !shut_q && misaligned_i) |=> (shut_q && $stable(base_q)));

  // R9: shutdown is sticky and freezes the base
  p_shut_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    shut_q |=> (shut_q && $stable(base_q)));
endmodule

// File: rtl/smbase_reloc.sv
module smbase_reloc #(
  parameter logic [31:0] RST_BASE      = 32'h0003_0000,
  parameter logic [31:0] HANDLER_OFS   = 32'h0000_8000,
  parameter logic [31:0] SAVE_LO_OFS   = 32'h0000_FE00,
  parameter logic [31:0] SAVE_HI_OFS   = 32'h0000_FFFF,
  parameter logic [31:0] BASE_FLD_OFS  = 32'h0000_FEF8,
  parameter logic [31:0] REV_FLD_OFS   = 32'h0000_FEFC,
  parameter int unsigned ALIGN_BITS    = 15,
  parameter logic        IO_RESTART_EN = 1'b1,
  parameter logic [15:0] SMM_VERSION   = 16'h0001
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        align_chk_en_i,
  input  logic        smi_entry_i,
  input  logic        resume_i,
  input  logic [31:0] saved_base_i,
  output logic [31:0] base_o,
  output logic [31:0] handler_o,
  output logic [31:0] save_lo_o,
  output logic [31:0] save_hi_o,
  output logic [31:0] rev_id_o,
  output logic [31:0] rev_addr_o,
  output logic        save_wr_o,
  output logic [31:0] save_addr_o,
  output logic [31:0] save_data_o,
  output logic        shutdown_o
);
  import smbase_pkg::*;

  localparam int unsigned AW = 32;
  localparam logic [NUM_TAPS-1:0][AW-1:0] TAP_OFS =
    {REV_FLD_OFS, BASE_FLD_OFS, SAVE_HI_OFS, SAVE_LO_OFS, HANDLER_OFS};
  localparam logic [31:0] REV_WORD = make_rev_word(IO_RESTART_EN, SMM_VERSION);

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [AW-1:0]               base_q;
  logic                        misaligned;
  logic [NUM_TAPS-1:0][AW-1:0] taps;

  smbase_addr_gen #(
    .AW  (AW),
    .N   (NUM_TAPS),
    .OFS (TAP_OFS)
  ) u_addr (
    .base_i (base_q),
    .addr_o (taps)
  );

  smbase_align_chk #(
    .AW         (AW),
    .ALIGN_BITS (ALIGN_BITS)
  ) u_align (
    .en_i         (align_chk_en_i),
    .value_i      (saved_base_i),
    .misaligned_o (misaligned)
  );

  smbase_core #(
    .AW       (AW),
    .RST_BASE (RST_BASE)
  ) u_core (
    .clk_i          (clk_i),
    .rst_n          (rst_sync_q),
    .init_i         (init_i),
    .smi_entry_i    (smi_entry_i),
    .resume_i       (resume_i),
    .saved_base_i   (saved_base_i),
    .misaligned_i   (misaligned),
    .align_chk_en_i (align_chk_en_i),
    .fld_addr_i     (taps[TAP_BASE_FLD]),
    .base_q         (base_q),
    .shut_q         (shutdown_o),
    .save_vld_q     (save_wr_o),
    .save_addr_q    (save_addr_o),
    .save_data_q    (save_data_o)
  );

  assign base_o     = base_q;
  assign handler_o  = taps[TAP_HANDLER];
  assign save_lo_o  = taps[TAP_SAVE_LO];
  assign save_hi_o  = taps[TAP_SAVE_HI];
  assign rev_addr_o = taps[TAP_REV_FLD];
  assign rev_id_o   = REV_WORD;

  // R5: handler address keeps its fixed distance from the base
  p_handler_r5: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    (handler_o - base_o) == HANDLER_OFS);

  // R6: save-area window spans a fixed size
  p_window_r6: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    (save_hi_o - save_lo_o) == (SAVE_HI_OFS - SAVE_LO_OFS));
endmodule

// File: tb/smbase_reloc_bench.sv
module smbase_reloc_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        init, chk_en, entry, resume;
  logic [31:0] saved;
  logic [31:0] base, handler, lo, hi, rev, rev_addr, s_addr, s_data;
  logic        s_wr, shut;
  int          checks = 0;
  int          fails  = 0;

  always #10 clk = ~clk;

  smbase_reloc u_smbase_reloc (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init), .align_chk_en_i(chk_en),
    .smi_entry_i(entry), .resume_i(resume), .saved_base_i(saved),
    .base_o(base), .handler_o(handler), .save_lo_o(lo), .save_hi_o(hi),
    .rev_id_o(rev), .rev_addr_o(rev_addr), .save_wr_o(s_wr),
    .save_addr_o(s_addr), .save_data_o(s_data), .shutdown_o(shut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_resume(input logic [31:0] v);
    @(negedge clk);
    saved  = v;
    resume = 1'b1;
    @(negedge clk);
    resume = 1'b0;
  endtask

  task automatic check_addrs(input logic [31:0] b);
    chk("R4 base", base, b);
    chk("R5 handler", handler, b + 32'h8000);
    chk("R6 save_lo", lo, b + 32'hFE00);
    chk("R6 save_hi", hi, b + 32'hFFFF);
    chk("R7 rev_addr", rev_addr, b + 32'hFEFC);
  endtask

  task automatic check_entry(input logic [31:0] b);
    @(negedge clk);
    entry = 1'b1;
    @(negedge clk);
    entry = 1'b0;
    chk("R3 save_wr", {31'b0, s_wr}, 32'd1);
    chk("R3 save_data", s_data, b);
    chk("R3 save_addr", s_addr, b + 32'hFEF8);
    @(negedge clk);
    chk("R3 single pulse", {31'b0, s_wr}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, prev;
    rst_n = 1'b0; init = 1'b0; chk_en = 1'b0; entry = 1'b0; resume = 1'b0;
    saved = 32'h0;
    do_reset();

    // R1 reset state and R7 identifier word
    chk("R1 base", base, 32'h0003_0000);
    chk("R1 shutdown", {31'b0, shut}, 32'd0);
    chk("R1 save_wr", {31'b0, s_wr}, 32'd0);
    chk("R7 rev_id", rev, 32'h0003_0001);
    check_addrs(32'h0003_0000);

    // R2: INIT and stray field changes do not move the base
    @(negedge clk);
    init  = 1'b1;
    saved = 32'h1234_5678;
    @(negedge clk);
    init = 1'b0;
    @(negedge clk);
    chk("R2 base after init", base, 32'h0003_0000);
    check_entry(32'h0003_0000);

    // R4/R5/R6/R3 sweep, check off: scattered values, unaligned accepted
    for (int i = 1; i < 40; i++) begin
      v = 32'(i) * 32'h9E37_79B9;
      do_resume(v);
      check_addrs(v);
      check_entry(v);
    end
    // R6 wrap near the top of the address space
    do_resume(32'hFFFF_8000);
    check_addrs(32'hFFFF_8000);
    chk("R5 wrap handler", handler, 32'h0000_0000);
    chk("R6 wrap save_hi", hi, 32'h0000_7FFF);

    // R10: entry and resume together
    prev = base;
    @(negedge clk);
    saved  = 32'h0050_0000;
    entry  = 1'b1;
    resume = 1'b1;
    @(negedge clk);
    entry  = 1'b0;
    resume = 1'b0;
    chk("R10 save_data old base", s_data, prev);
    chk("R10 save_addr old base", s_addr, prev + 32'hFEF8);
    chk("R10 base new", base, 32'h0050_0000);

    // R8: aligned sweep with check on stays up
    chk_en = 1'b1;
    for (int k = 0; k < 16; k++) begin
      v = 32'h1000_0000 + 32'(k) * 32'h8000;
      do_resume(v);
      chk("R8 aligned no shutdown", {31'b0, shut}, 32'd0);
      chk("R8 aligned base", base, v);
    end
    prev = base;
    do_resume(prev + 32'h4000);
    chk("R8 bit14 shutdown", {31'b0, shut}, 32'd1);
    chk("R8 base kept", base, prev);
    // R9: further resumes ignored
    do_resume(32'h0020_0000);
    chk("R9 still shutdown", {31'b0, shut}, 32'd1);
    chk("R9 base frozen", base, prev);
    do_resume(32'h0040_0000);
    chk("R9 base frozen again", base, prev);

    // R1 reset clears shutdown; R8 low bit also trips
    do_reset();
    chk("R1 base after reset", base, 32'h0003_0000);
    chk("R1 shutdown cleared", {31'b0, shut}, 32'd0);
    do_resume(32'h0008_0001);
    chk("R8 bit0 shutdown", {31'b0, shut}, 32'd1);
    chk("R8 bit0 base kept", base, 32'h0003_0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule